// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Bit Error Detector

This block sits on the receive side of a bit-error test path. It runs on the receive clock, which may be gapped, and takes one serial NRZ bit per enabled edge. It is set up with the same pattern settings as the matching generator: a mode select (pseudorandom or repetitive), a length field and a feedback tap field. It searches the incoming stream for that pattern and declares lock once a long enough run of bits matches the pattern's own prediction rule. After lock, it compares every received bit against a free-running internal reference and flags each bit that differs.

Lock is dropped when errors become too dense, unless that automatic drop is switched off. A rising edge on a resync strobe also forces a new search. Two run detectors report long strings of ones or zeros. These cover the degenerate streams that also satisfy a pseudorandom rule. A capture strobe takes a 32-bit snapshot: the raw recent history while searching, or the locked reference while in lock. Counting of bits and errors is left to logic outside the block. That logic uses the per-bit error pulse and the count-enable pulse.

Top module: `patsync_checker`

## Requirements
- R1: In search, each enabled bit that matches the prediction extends a run, and a mismatch resets the run to zero. Lock is declared at the enabled edge that completes a run of 35 + len_sel matching bits. In repetitive mode with an all-zero stream straight after reset, `locked` therefore reads 1 after exactly 35 + len_sel bits, and not after 34 + len_sel bits.
- R2: Let ref[0] be the newest bit of a 32-bit reference history. In pseudorandom mode (prbs_mode = 1) the predicted bit is ref[len_sel] XOR ref[tap_sel]. In repetitive mode it is ref[len_sel]. During search the reference takes in received bits. During lock it takes in its own predictions, so a single corrupted bit gives exactly one error pulse.
- R3: With auto_resync_off = 0, lock is lost at the enabled edge whose bit brings the error count over the last 64 locked bits to 6 or more. Errors that have aged out of that 64-bit window do not count. With auto_resync_off = 1, errors never drop lock.
- R4: At a clock edge where resync_req is seen rising, the checker returns to search and clears its run, whether or not rx_hold is set. It can then lock again by the rule in R1.
- R5: At an edge with rx_hold = 1, no bit is taken in. The lock state, the reference history, the run detectors and the error window keep their values, and bit_valid and bit_err stay 0.
- R6: With rx_invert = 1, the received bit is inverted before any checking, run detection or history capture.
- R7: With loop_sel = 1, loop_data replaces rx_data as the received bit, and rx_data has no effect.
- R8: bit_valid is a one-cycle registered pulse, high after each enabled edge taken while locked. bit_err is high in that same cycle when the bit mismatched its prediction. Both stay 0 while searching.
- R9: ones_run rises at the enabled edge of the 32nd consecutive received 1 and clears at the next received 0.
- R10: zeros_run rises at the enabled edge of the 32nd consecutive received 0 and clears at the next received 1.
- R11: At an edge where capture_req is seen rising while searching, snap_word takes the last 32 received bits. Bit 0 holds the most recent of them, and bits taken in at that same edge are excluded.
- R12: A capture taken while locked stores the reference pattern in some rotation, so bits received in error do not appear in it.
- R13: After reset, locked, bit_err, bit_valid, ones_run and zeros_run are 0 and snap_word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, may be gapped |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 1 | Serial receive data |
| rx_hold | input | 1 | High: skip this edge's bit and freeze the data path |
| rx_invert | input | 1 | Invert the received bit before checking |
| loop_sel | input | 1 | Select loop_data instead of rx_data |
| loop_data | input | 1 | Transmitted bit, used when loop_sel is high |
| prbs_mode | input | 1 | 1 = pseudorandom rule, 0 = repetitive rule |
| len_sel | input | 5 | Pattern length minus one (first tap) |
| tap_sel | input | 5 | Second feedback tap position (pseudorandom mode) |
| auto_resync_off | input | 1 | 1 = never drop lock on error density |
| resync_req | input | 1 | Rising edge forces a new search |
| capture_req | input | 1 | Rising edge captures snap_word |
| locked | output | 1 | Lock state |
| bit_err | output | 1 | One-cycle pulse: the locked bit mismatched |
| bit_valid | output | 1 | One-cycle pulse: a locked bit was checked |
| ones_run | output | 1 | 32 or more consecutive ones seen |
| zeros_run | output | 1 | 32 or more consecutive zeros seen |
| snap_word | output | 32 | Captured history or reference |

## Verification
The lock-timing assertion takes for granted that len_sel does not change during the cycle that completes a run. The drop-cause assertion takes for granted that auto_resync_off is steady around the edge that ends lock. The stimulus changes mode, length and tap fields only while reset is held, and it changes auto_resync_off only between bursts. Strobes are raised for one clock while rx_hold is high, so a capture never mixes with a new data bit. All inputs change 2 ns after a rising edge, well clear of the sampling edge.

// File: rtl/patsync_pkg.sv
package patsync_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } sync_st_t;
endpackage

// File: rtl/patsync_ref.sv
// Reference history with next-bit prediction for both pattern kinds.
module patsync_ref #(
  parameter int W  = 32,
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          use_pred,
  input  logic          din,
  input  logic          prbs_mode,
  input  logic [LW-1:0] len_sel,
  input  logic [LW-1:0] tap_sel,
  output logic          pred,
  output logic [W-1:0]  ref_word
);
  logic [W-1:0] ref_q;

  always_comb begin
    if (prbs_mode) pred = ref_q[len_sel] ^ ref_q[tap_sel];
    else           pred = ref_q[len_sel];
  end

  always_ff @(posedge clk) begin
    if (rst)           ref_q <= '0;
    else if (shift_en) ref_q <= {ref_q[W-2:0], (use_pred ? pred : din)};
  end

  assign ref_word = ref_q;

  // R5: no edge without shift enable may move the history
  assert_ref_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(shift_en) |-> $stable(ref_q));
endmodule

// File: rtl/patsync_errwin.sv
// Sliding window of error flags with a running population count.
module patsync_errwin #(
  parameter int WIN   = 64,
  parameter int LIMIT = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic push,
  input  logic err_in,
  output logic over
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] win_q;
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_next;

  always_comb begin
    cnt_next = cnt_q + CW'(err_in) - CW'(win_q[WIN-1]);
    over     = push && (cnt_next >= CW'(LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (push) begin
      win_q <= {win_q[WIN-2:0], err_in};
      cnt_q <= cnt_next;
    end
  end

  // R3: running count always equals the flags held in the window
  assert_count_tracks_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q == CW'($countones(win_q)));
endmodule

// File: rtl/patsync_run.sv
// Detector for a long run of one polarity.
module patsync_run #(
  parameter int RUN = 32,
  parameter bit POL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic flag_q
);
  localparam int NW = $clog2(RUN + 1);

  logic [NW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (en) begin
      if (din == POL) begin
        if (cnt_q < NW'(RUN)) cnt_q <= cnt_q + 1'b1;
        flag_q <= (cnt_q >= NW'(RUN - 1));
      end else begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end
    end
  end

  // R9 (ones) / R10 (zeros): flag only rises on an accepted bit of its polarity
  assert_run_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> ($past(en) && ($past(din) == POL)));
endmodule

// File: rtl/patsync_checker.sv
module patsync_checker #(
  parameter int W         = 32,
  parameter int LW        = 5,
  parameter int WIN       = 64,
  parameter int ERR_LIMIT = 6,
  parameter int RUN       = 32,
  parameter int EXTRA     = 34
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_data,
  input  logic          rx_hold,
  input  logic          rx_invert,
  input  logic          loop_sel,
  input  logic          loop_data,
  input  logic          prbs_mode,
  input  logic [LW-1:0] len_sel,
  input  logic [LW-1:0] tap_sel,
  input  logic          auto_resync_off,
  input  logic          resync_req,
  input  logic          capture_req,
  output logic          locked,
  output logic          bit_err,
  output logic          bit_valid,
  output logic          ones_run,
  output logic          zeros_run,
  output logic [W-1:0]  snap_word
);
  import patsync_pkg::*;

  localparam int RCW = $clog2(EXTRA + W + 2);

  sync_st_t       state_q;
  logic [RCW-1:0] run_q;
  logic [RCW-1:0] thr;
  logic           rs_q, cap_q;
  logic           rs_rise, cap_rise;
  logic           en, rx_bit, pred, mismatch;
  logic           win_over, win_clr, win_push;
  logic [W-1:0]   ref_word;
  logic [1:0]     run_flags;

  always_comb begin
    en       = !rx_hold;
    rx_bit   = (loop_sel ? loop_data : rx_data) ^ rx_invert;
    mismatch = rx_bit ^ pred;
    rs_rise  = resync_req && !rs_q;
    cap_rise = capture_req && !cap_q;
    thr      = RCW'(EXTRA + 1) + RCW'(len_sel);
    win_clr  = rs_rise || (state_q == ST_SEARCH);
    win_push = en && (state_q == ST_LOCK) && !rs_rise;
  end

  assign locked = (state_q == ST_LOCK);

  patsync_ref #(.W(W), .LW(LW)) u_ref (
    .clk(clk), .rst(rst), .shift_en(en), .use_pred(locked), .din(rx_bit),
    .prbs_mode(prbs_mode), .len_sel(len_sel), .tap_sel(tap_sel),
    .pred(pred), .ref_word(ref_word)
  );

  patsync_errwin #(.WIN(WIN), .LIMIT(ERR_LIMIT)) u_win (
    .clk(clk), .rst(rst), .clr(win_clr), .push(win_push),
    .err_in(mismatch), .over(win_over)
  );

  for (genvar p = 0; p < 2; p++) begin : g_run
    patsync_run #(.RUN(RUN), .POL(p[0])) u_run (
      .clk(clk), .rst(rst), .en(en), .din(rx_bit), .flag_q(run_flags[p])
    );
  end

  assign zeros_run = run_flags[0];
  assign ones_run  = run_flags[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_SEARCH;
      run_q     <= '0;
      bit_err   <= 1'b0;
      bit_valid <= 1'b0;
      snap_word <= '0;
      rs_q      <= 1'b0;
      cap_q     <= 1'b0;
    end else begin
      rs_q      <= resync_req;
      cap_q     <= capture_req;
      bit_err   <= 1'b0;
      bit_valid <= 1'b0;
      if (cap_rise) snap_word <= ref_word;
      if (rs_rise) begin
        state_q <= ST_SEARCH;
        run_q   <= '0;
      end else if (en) begin
        case (state_q)
          ST_SEARCH: begin
            if (mismatch) begin
              run_q <= '0;
            end else if (run_q + 1'b1 >= thr) begin
              state_q <= ST_LOCK;
              run_q   <= '0;
            end else begin
              run_q <= run_q + 1'b1;
            end
          end
          default: begin
            bit_valid <= 1'b1;
            bit_err   <= mismatch;
            if (win_over && !auto_resync_off) state_q <= ST_SEARCH;
          end
        endcase
      end
    end
  end

  // R1: lock only follows a completed run of matching bits
  assert_lock_run_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (($past(run_q) + 1'b1) == $past(thr)));

  // R8: error pulse only with a valid pulse, and valid only from the lock state
  assert_err_valid_R8: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> bit_valid);
  assert_valid_locked_R8: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> $past(locked));

  // R4: a resync edge always lands in search
  assert_resync_search_R4: assert property (@(posedge clk) disable iff (rst)
    $past(rs_rise) |-> !locked);

  // R5: a held edge changes no lock state and produces no pulse
  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(rx_hold) && !$past(rs_rise)) |-> ((locked == $past(locked)) && !bit_valid));

  // R3: lock ends only by resync or by an error-dense window with auto drop on
  assert_drop_cause_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(locked) && !$past(rs_rise)) |-> ($past(win_over) && !$past(auto_resync_off)));
endmodule

// File: tb/patsync_checker_bench.sv
module patsync_checker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_data = 1'b0, rx_hold = 1'b0, rx_invert = 1'b0;
  logic        loop_sel = 1'b0, loop_data = 1'b0, prbs_mode = 1'b0;
  logic [4:0]  len_sel = 5'd0, tap_sel = 5'd0;
  logic        auto_resync_off = 1'b0, resync_req = 1'b0, capture_req = 1'b0;
  logic        locked, bit_err, bit_valid, ones_run, zeros_run;
  logic [31:0] snap_word;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  patsync_checker u_patsync_checker (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_hold(rx_hold),
    .rx_invert(rx_invert), .loop_sel(loop_sel), .loop_data(loop_data),
    .prbs_mode(prbs_mode), .len_sel(len_sel), .tap_sel(tap_sel),
    .auto_resync_off(auto_resync_off), .resync_req(resync_req),
    .capture_req(capture_req), .locked(locked), .bit_err(bit_err),
    .bit_valid(bit_valid), .ones_run(ones_run), .zeros_run(zeros_run),
    .snap_word(snap_word)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic push(input logic b);
    rx_data = b;
    tick();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic capture();
    rx_hold = 1'b1;
    capture_req = 1'b1;
    tick();
    capture_req = 1'b0;
    rx_hold = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [0:511] hist;
    int nerr;
    int k;
    tick();
    do_reset();
    // R13 reset state
    chk("R13", "locked", {31'd0, locked}, 32'd0);
    chk("R13", "pulses", {30'd0, bit_err, bit_valid}, 32'd0);
    chk("R13", "run flags", {30'd0, ones_run, zeros_run}, 32'd0);
    chk("R13", "snap", snap_word, 32'd0);

    // R1 sweep over every length: zeros stream, repetitive mode
    for (int len = 0; len < 32; len++) begin
      len_sel = 5'(len);
      do_reset();
      for (int i = 0; i < 34 + len; i++) push(1'b0);
      chk("R1", "not yet locked", {31'd0, locked}, 32'd0);
      chk("R8", "no valid in search", {31'd0, bit_valid}, 32'd0);
      push(1'b0);
      chk("R1", "locked at 35+len", {31'd0, locked}, 32'd1);
    end

    // R8 / R3: error pulses and density drop, len 3 (run 38)
    len_sel = 5'd3;
    do_reset();
    for (int i = 0; i < 38; i++) push(1'b0);
    push(1'b0);
    chk("R8", "valid pulse", {31'd0, bit_valid}, 32'd1);
    chk("R8", "no error", {31'd0, bit_err}, 32'd0);
    push(1'b1);
    chk("R8", "error pulse", {31'd0, bit_err}, 32'd1);
    push(1'b0);
    chk("R8", "error clears", {31'd0, bit_err}, 32'd0);
    for (int i = 0; i < 4; i++) begin push(1'b1); push(1'b0); push(1'b0); end
    chk("R3", "5 errors keep lock", {31'd0, locked}, 32'd1);
    for (int i = 0; i < 64; i++) push(1'b0);
    for (int i = 0; i < 5; i++) begin push(1'b1); push(1'b0); end
    chk("R3", "aged errors do not count", {31'd0, locked}, 32'd1);
    push(1'b1);
    chk("R3", "6th error drops lock", {31'd0, locked}, 32'd0);
    chk("R8", "error pulse on drop", {31'd0, bit_err}, 32'd1);

    // R3 with auto drop off, then R12 capture in lock
    auto_resync_off = 1'b1;
    do_reset();
    for (int i = 0; i < 38; i++) push(1'b0);
    for (int i = 0; i < 10; i++) push(1'b1);
    chk("R3", "auto off keeps lock", {31'd0, locked}, 32'd1);
    capture();
    chk("R12", "locked capture hides errors", snap_word, 32'd0);

    // R4 resync while held
    rx_hold = 1'b1;
    resync_req = 1'b1;
    tick();
    resync_req = 1'b0;
    rx_hold = 1'b0;
    chk("R4", "resync to search", {31'd0, locked}, 32'd0);
    for (int i = 0; i < 37; i++) push(1'b0);
    chk("R4", "relock not early", {31'd0, locked}, 32'd0);
    push(1'b0);
    chk("R4", "relock after run", {31'd0, locked}, 32'd1);

    // R5 hold while locked
    rx_hold = 1'b1;
    nerr = 0;
    for (int i = 0; i < 10; i++) begin
      push(1'b1);
      if (bit_valid || bit_err || !locked) nerr++;
    end
    rx_hold = 1'b0;
    chk("R5", "held edges silent", 32'(nerr), 32'd0);
    push(1'b0);
    chk("R5", "no error after hold", {31'd0, bit_err}, 32'd0);
    auto_resync_off = 1'b0;

    // R11 capture in search, R5 history frozen
    len_sel = 5'd31;
    do_reset();
    v = 32'hC3A596F1;
    for (int i = 31; i >= 0; i--) push(v[i]);
    capture();
    chk("R11", "history capture", snap_word, v);
    rx_hold = 1'b1;
    for (int i = 0; i < 8; i++) push(i[0]);
    rx_hold = 1'b0;
    capture();
    chk("R5", "history frozen by hold", snap_word, v);
    push(1'b1); push(1'b0); push(1'b1); push(1'b0);
    capture();
    chk("R11", "history shifted", snap_word, {v[27:0], 4'b1010});

    // R6 inversion, len 5 (run 40)
    len_sel = 5'd5;
    rx_invert = 1'b1;
    do_reset();
    for (int i = 0; i < 39; i++) push(1'b1);
    chk("R6", "inverted not yet locked", {31'd0, locked}, 32'd0);
    push(1'b1);
    chk("R6", "inverted ones lock as zeros", {31'd0, locked}, 32'd1);
    push(1'b0);
    chk("R6", "inverted zero is an error", {31'd0, bit_err}, 32'd1);
    rx_invert = 1'b0;

    // R7 loopback
    loop_sel = 1'b1;
    loop_data = 1'b0;
    do_reset();
    for (int i = 0; i < 40; i++) push(1'b1);
    chk("R7", "loopback lock ignores rx_data", {31'd0, locked}, 32'd1);
    push(1'b1);
    chk("R7", "rx_data has no effect", {31'd0, bit_err}, 32'd0);
    loop_data = 1'b1;
    push(1'b0);
    chk("R7", "loop_data error seen", {31'd0, bit_err}, 32'd1);
    loop_sel = 1'b0;
    loop_data = 1'b0;

    // R9 / R10 run detectors
    do_reset();
    for (int i = 0; i < 31; i++) push(1'b1);
    chk("R9", "31 ones", {31'd0, ones_run}, 32'd0);
    push(1'b1);
    chk("R9", "32 ones", {31'd0, ones_run}, 32'd1);
    push(1'b0);
    chk("R9", "zero clears", {31'd0, ones_run}, 32'd0);
    for (int i = 0; i < 30; i++) push(1'b0);
    chk("R10", "31 zeros", {31'd0, zeros_run}, 32'd0);
    push(1'b0);
    chk("R10", "32 zeros", {31'd0, zeros_run}, 32'd1);
    push(1'b1);
    chk("R10", "one clears", {31'd0, zeros_run}, 32'd0);

    // R2 pseudorandom: b[k] = b[k-7] ^ b[k-6], len 6, tap 5
    prbs_mode = 1'b1;
    len_sel = 5'd6;
    tap_sel = 5'd5;
    do_reset();
    hist = '0;
    for (int i = 0; i < 7; i++) hist[i] = 1'b1;
    for (int i = 7; i < 512; i++) hist[i] = hist[i-7] ^ hist[i-6];
    k = 0;
    for (int i = 0; i < 150; i++) begin push(hist[k]); k++; end
    chk("R2", "pseudorandom lock", {31'd0, locked}, 32'd1);
    nerr = 0;
    for (int i = 0; i < 100; i++) begin push(hist[k]); k++; if (bit_err) nerr++; end
    chk("R2", "clean stream no errors", 32'(nerr), 32'd0);
    nerr = 0;
    push(~hist[k]); k++;
    if (bit_err) nerr++;
    for (int i = 0; i < 20; i++) begin push(hist[k]); k++; if (bit_err) nerr++; end
    chk("R2", "single flip single pulse", 32'(nerr), 32'd1);

    // R2 repetitive period 4, R12 rotation of reference
    prbs_mode = 1'b0;
    len_sel = 5'd3;
    do_reset();
    for (int i = 0; i < 60; i++) push(i % 4 == 0);
    chk("R2", "repetitive lock", {31'd0, locked}, 32'd1);
    push(1'b1);
    push(1'b1);
    chk("R2", "repetitive error", {31'd0, bit_err}, 32'd1);
    capture();
    chk("R12", "rotation of reference",
        {31'd0, (snap_word == 32'h88888888) || (snap_word == 32'h44444444) ||
                (snap_word == 32'h22222222) || (snap_word == 32'h11111111)}, 32'd1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule